// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This unit sits beside a bus and judges every access against sixteen programmable protection areas. Each area has a power-of-two size from 1 KB to 1 MB, a base aligned to that size, an enable bit, and two restriction bits: one forbids writes and one forbids user-mode access. Every access brings an address, a write flag and a user flag. The unit raises a violation flag in the same cycle when the access breaks the restrictions of the area that governs it.

The top 256 MB of the address space is the peripheral region. The areas do not govern it. It has its own pair of restriction bits, held in the control register together with the global enable. When the global enable is clear, every check is bypassed.

Software programs the unit through a small indexed register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `mem_guard_top`

## Requirements
- R1: After reset every register reads as zero, the unit is globally disabled, and `violation` and `hitAny` are low.
- R2: Register index 0 to 15 selects the area word of that area. The area word holds the enable in bit 0, no-write in bit 1, no-user in bit 2, the size code in bits 7:4 and the base in bits 31:10. Index 16 is the control word: global enable in bit 0, peripheral no-write in bit 1, peripheral no-user in bit 2. Undefined bits read back as zero.
- R3: An enabled area matches an address when bits 31:L of the address equal bits 31:L of its base, where L = 10 + size code. Size codes above 10 act as 10, giving 1 MB.
- R4: An area whose enable bit is clear never matches.
- R5: When several areas match, the lowest-numbered one decides. `hitIdx` reports its number.
- R6: A write to an area with no-write set is a violation. A read from that area is not.
- R7: A user-mode access to an area with no-user set is a violation. A privileged access to that area is not.
- R8: An address outside the peripheral region that matches no enabled area is allowed, and `hitAny` stays low.
- R9: Addresses with bits 31:28 = 4'hF are judged only by the peripheral restriction bits. Areas are ignored there, and `hitAny` stays low.
- R10: With the global enable clear, `violation` and `hitAny` stay low for every access.
- R11: `violation`, `hitAny` and `hitIdx` follow the access inputs combinationally in the same cycle. They are low (`hitIdx` zero) while `accValid` is low.
- R12: Writes to register indices above 16 change no register, and reads of those indices return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgIdx | input | 5 | Register index |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Register read data for `cfgIdx` |
| accValid | input | 1 | Access present this cycle |
| accAddr | input | 32 | Access address |
| accWrite | input | 1 | 1 = write, 0 = read |
| accUser | input | 1 | 1 = user mode, 0 = privileged |
| violation | output | 1 | Access breaks its protection |
| hitAny | output | 1 | An enabled area governs the access |
| hitIdx | output | 4 | Number of the governing area |

## Verification
Two areas can match one address in the same cycle. The bench provokes this by programming a 1 MB area with only no-user set below a 1 KB area that has no-write, both covering the same address. A privileged write there must pass and report the lower area number, because the higher area alone would have flagged it. A register write and an access can also coincide in one cycle. The random phase mixes the two, and the bench judges each access just after the edge against the attributes that the write has just installed.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;
  typedef enum logic [1:0] {RD_NONE, RD_AREA, RD_CTRL} rd_sel_e;

  typedef struct packed {
    logic    areaLoad;
    logic    ctrlLoad;
    rd_sel_e rdSel;
    logic [7:0] areaNum;
  } cfg_stb_t;

  // bit 0 enable, bit 1 no-write, bit 2 no-user
  typedef struct packed {
    logic noUsr;
    logic noWr;
    logic en;
  } attr_t;
endpackage

// File: rtl/mem_guard_ctl.sv
module mem_guard_ctl
  import mem_guard_pkg::*;
#(
  parameter int NUM_AREAS = 16,
  parameter int CFG_IDX_W = $clog2(NUM_AREAS + 1)
) (
  input  logic                 cfgWe,
  input  logic [CFG_IDX_W-1:0] cfgIdx,
  output cfg_stb_t             stb
);
  // Decode the register index into load and read-select strobes
  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    if (cfgIdx < CFG_IDX_W'(NUM_AREAS)) begin
      stb.rdSel    = RD_AREA;
      stb.areaLoad = cfgWe;
      stb.areaNum  = 8'(cfgIdx);
    end else if (cfgIdx == CFG_IDX_W'(NUM_AREAS)) begin
      stb.rdSel    = RD_CTRL;
      stb.ctrlLoad = cfgWe;
    end
  end
endmodule

// File: rtl/mem_guard_dp.sv
module mem_guard_dp
  import mem_guard_pkg::*;
#(
  parameter int NUM_AREAS  = 16,
  parameter int ADDR_W     = 32,
  parameter int MIN_LOG    = 10,
  parameter int MAX_LOG    = 20,
  parameter int CODE_W     = 4,
  parameter int PERIPH_LOG = 28,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'hF000_0000,
  parameter int AIDX_W     = $clog2(NUM_AREAS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_stb_t          stb,
  input  logic [ADDR_W-1:0] cfgWdata,
  output logic [ADDR_W-1:0] cfgRdata,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              accUser,
  output logic              violation,
  output logic              hitAny,
  output logic [AIDX_W-1:0] hitIdx,
  output logic              unitEn
);
  localparam int BASE_W  = ADDR_W - MIN_LOG;
  localparam int SPAN    = MAX_LOG - MIN_LOG;
  localparam int LOW_PAD = MIN_LOG - CODE_W - 4;

  logic [NUM_AREAS-1:0][BASE_W-1:0] areaBase;
  logic [NUM_AREAS-1:0][CODE_W-1:0] areaCode;
  attr_t [NUM_AREAS-1:0]            areaAttr;
  logic [NUM_AREAS-1:0]             match;
  logic [AIDX_W-1:0]                rdN;
  attr_t                            ctrlQ;

  assign rdN = stb.areaNum[AIDX_W-1:0];

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
    logic [BASE_W-1:0] baseQ;
    logic [CODE_W-1:0] codeQ;
    attr_t             attrQ;
    logic [CODE_W-1:0] effLog;
    logic [BASE_W-1:0] spanMask;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ <= '0;
        codeQ <= '0;
        attrQ <= '0;
      end else if (stb.areaLoad && rdN == AIDX_W'(i)) begin
        baseQ <= cfgWdata[ADDR_W-1:MIN_LOG];
        codeQ <= cfgWdata[CODE_W+3:4];
        attrQ <= attr_t'(cfgWdata[2:0]);
      end
    end

    // Size codes beyond the largest size saturate
    assign effLog   = (codeQ > CODE_W'(SPAN)) ? CODE_W'(SPAN) : codeQ;
    assign spanMask = ~((BASE_W'(1) << effLog) - BASE_W'(1));
    assign match[i] = attrQ.en &&
                      (((accAddr[ADDR_W-1:MIN_LOG] ^ baseQ) & spanMask) == '0);
    assign areaBase[i] = baseQ;
    assign areaCode[i] = codeQ;
    assign areaAttr[i] = attrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ctrlQ <= '0;
    else if (stb.ctrlLoad) ctrlQ <= attr_t'(cfgWdata[2:0]);
  end

  // Lowest-numbered matching area wins
  logic [AIDX_W-1:0] firstIdx;
  logic              anyMatch;
  always_comb begin
    firstIdx = '0;
    anyMatch = 1'b0;
    for (int k = NUM_AREAS - 1; k >= 0; k--) begin
      if (match[k]) begin
        anyMatch = 1'b1;
        firstIdx = AIDX_W'(k);
      end
    end
  end

  logic  inPeriph;
  attr_t selAttr;
  logic  active;

  assign inPeriph = accAddr[ADDR_W-1:PERIPH_LOG] == PERIPH_BASE[ADDR_W-1:PERIPH_LOG];
  assign active   = accValid && ctrlQ.en;

  always_comb begin
    if (inPeriph)      selAttr = '{noUsr: ctrlQ.noUsr, noWr: ctrlQ.noWr, en: 1'b1};
    else if (anyMatch) selAttr = areaAttr[firstIdx];
    else               selAttr = '0;
  end

  assign violation = active && selAttr.en &&
                     ((selAttr.noWr && accWrite) || (selAttr.noUsr && accUser));
  assign hitAny    = active && !inPeriph && anyMatch;
  assign hitIdx    = hitAny ? firstIdx : '0;
  assign unitEn    = ctrlQ.en;

  always_comb begin
    case (stb.rdSel)
      RD_AREA: cfgRdata = {areaBase[rdN], {LOW_PAD{1'b0}}, areaCode[rdN], 1'b0, areaAttr[rdN]};
      RD_CTRL: cfgRdata = {{(ADDR_W-3){1'b0}}, ctrlQ};
      default: cfgRdata = '0;
    endcase
  end

  logic unusedBits;
  assign unusedBits = ^{cfgWdata[MIN_LOG-1:CODE_W+4], cfgWdata[3],
                        stb.areaNum[7:AIDX_W], accAddr[MIN_LOG-1:0]};
endmodule

// File: rtl/mem_guard_top.sv
module mem_guard_top
  import mem_guard_pkg::*;
#(
  parameter int NUM_AREAS  = 16,
  parameter int ADDR_W     = 32,
  parameter int MIN_LOG    = 10,
  parameter int MAX_LOG    = 20,
  parameter int CODE_W     = 4,
  parameter int PERIPH_LOG = 28,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'hF000_0000
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgWe,
  input  logic [$clog2(NUM_AREAS+1)-1:0] cfgIdx,
  input  logic [ADDR_W-1:0]              cfgWdata,
  output logic [ADDR_W-1:0]              cfgRdata,
  input  logic                           accValid,
  input  logic [ADDR_W-1:0]              accAddr,
  input  logic                           accWrite,
  input  logic                           accUser,
  output logic                           violation,
  output logic                           hitAny,
  output logic [$clog2(NUM_AREAS)-1:0]   hitIdx
);
  localparam int CFG_IDX_W = $clog2(NUM_AREAS + 1);
  localparam int AIDX_W    = $clog2(NUM_AREAS);

  cfg_stb_t stb;
  logic     unitEn;

  mem_guard_ctl #(.NUM_AREAS(NUM_AREAS), .CFG_IDX_W(CFG_IDX_W)) u_ctl (
    .cfgWe (cfgWe),
    .cfgIdx(cfgIdx),
    .stb   (stb)
  );

  mem_guard_dp #(
    .NUM_AREAS(NUM_AREAS), .ADDR_W(ADDR_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG),
    .CODE_W(CODE_W), .PERIPH_LOG(PERIPH_LOG), .PERIPH_BASE(PERIPH_BASE), .AIDX_W(AIDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .accValid (accValid),
    .accAddr  (accAddr),
    .accWrite (accWrite),
    .accUser  (accUser),
    .violation(violation),
    .hitAny   (hitAny),
    .hitIdx   (hitIdx),
    .unitEn   (unitEn)
  );
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
  parameter int ADDR_W     = 32,
  parameter int CFG_IDX_W  = 5,
  parameter int PERIPH_LOG = 28,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 32'hF000_0000
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgWe,
  input logic [CFG_IDX_W-1:0] cfgIdx,
  input logic [ADDR_W-1:0]    cfgRdata,
  input logic                 accValid,
  input logic [ADDR_W-1:0]    accAddr,
  input logic                 accWrite,
  input logic                 accUser,
  input logic                 violation,
  input logic                 hitAny,
  input logic                 unitEn
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cfgRdata == '0)); // R1

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> (!$stable(cfgIdx) || $stable(cfgRdata))); // R2

  AST_PRIV_READ_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && !accUser) |-> !violation); // R6

  AST_PERIPH_NO_AREA: assert property (@(posedge clk) disable iff (!rstN)
    (accAddr[ADDR_W-1:PERIPH_LOG] == PERIPH_BASE[ADDR_W-1:PERIPH_LOG]) |-> !hitAny); // R9

  AST_BYPASS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !unitEn |-> (!violation && !hitAny)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!violation && !hitAny)); // R11
endmodule

bind mem_guard_top mem_guard_chk #(
  .ADDR_W(ADDR_W), .CFG_IDX_W(CFG_IDX_W), .PERIPH_LOG(PERIPH_LOG), .PERIPH_BASE(PERIPH_BASE)
) u_chk (.*);

// File: tb/mem_guard_top_tb.sv
module mem_guard_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgIdx = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accWrite = 1'b0;
  logic        accUser = 1'b0;
  logic        violation;
  logic        hitAny;
  logic [3:0]  hitIdx;

  int nChecks = 0;
  int nErr = 0;

  logic [31:0] mArea [16];
  logic [31:0] mCtrl;

  always #5 clk = ~clk;

  mem_guard_top u_dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference of the protection decision
  task automatic predict(input logic [31:0] a, input logic w, input logic u, input logic v,
                         output logic ev, output logic eh, output logic [3:0] ei);
    bit found = 0;
    ev = 0; eh = 0; ei = 0;
    if (v && mCtrl[0]) begin
      if (a[31:28] == 4'hF) begin
        ev = (w && mCtrl[1]) || (u && mCtrl[2]);
      end else begin
        for (int i = 0; i < 16; i++) begin
          int code = int'(mArea[i][7:4]);
          int lg = 10 + ((code > 10) ? 10 : code);
          if (!found && mArea[i][0] && ((a >> lg) == (mArea[i] >> lg))) begin
            found = 1; eh = 1; ei = 4'(i);
            ev = (w && mArea[i][1]) || (u && mArea[i][2]);
          end
        end
      end
    end
  endtask

  function automatic logic [31:0] readModel(input logic [4:0] idx);
    if (idx < 16) return mArea[idx];
    if (idx == 16) return mCtrl;
    return 32'h0;
  endfunction

  task automatic cyc(input logic we, input logic [4:0] idx, input logic [31:0] wd,
                     input logic v, input logic [31:0] a, input logic w, input logic u,
                     input string req);
    logic ev, eh;
    logic [3:0] ei;
    cfgWe = we; cfgIdx = idx; cfgWdata = wd;
    accValid = v; accAddr = a; accWrite = w; accUser = u;
    @(posedge clk);
    if (we && rstN) begin
      if (idx < 16) mArea[idx] = wd & 32'hFFFF_FCF7;
      else if (idx == 16) mCtrl = wd & 32'h7;
    end
    #2;
    predict(a, w, u, v, ev, eh, ei);
    chk(req, "violation", 32'(violation), 32'(ev));
    chk(req, "hitAny", 32'(hitAny), 32'(eh));
    chk(req, "hitIdx", 32'(hitIdx), 32'(ei));
    chk(req, "cfgRdata", cfgRdata, readModel(idx));
    @(negedge clk);
  endtask

  task automatic acc(input logic [31:0] a, input logic w, input logic u, input string req);
    cyc(1'b0, 5'd0, 32'h0, 1'b1, a, w, u, req);
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] wd, input string req);
    cyc(1'b1, idx, wd, 1'b0, 32'h0, 1'b0, 1'b0, req);
  endtask

  initial begin
    #1_000_000;
    nErr++;
    $display("FAIL R11 watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mArea[i] = '0;
    mCtrl = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    cyc(1'b0, 5'd0, 32'h0, 1'b1, 32'h0000_0100, 1'b1, 1'b1, "R1");
    chk("R1", "area0 after reset", cfgRdata, 32'h0);
    chk("R1", "violation after reset", 32'(violation), 32'h0);

    // R2: program areas and read back
    wr(5'd0,  32'h0000_0003, "R2");          // 1 KB at 0, no-write
    wr(5'd3,  32'h0010_00A5, "R2");          // 1 MB at 0x0010_0000, no-user
    wr(5'd5,  32'h0010_0403, "R2");          // 1 KB at 0x0010_0400, no-write
    wr(5'd7,  32'h2000_00A2, "R4");          // disabled area
    wr(5'd9,  32'h3000_00F3, "R3");          // code 15 -> 1 MB, no-write
    wr(5'd12, 32'hF000_00A3, "R9");          // covers the peripheral region
    wr(5'd1,  32'hFFFF_FFFF, "R2");
    chk("R2", "undefined bits masked", cfgRdata, 32'hFFFF_FCF7);
    wr(5'd1,  32'h0, "R2");
    cyc(1'b0, 5'd3, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, "R2");
    chk("R2", "area3 readback", cfgRdata, 32'h0010_00A5);

    // R10: globally disabled, a no-write area is bypassed
    acc(32'h0000_0100, 1'b1, 1'b1, "R10");
    chk("R10", "bypass when disabled", 32'(violation), 32'h0);

    wr(5'd16, 32'h0000_0005, "R2");          // enable, peripheral no-user

    acc(32'h0000_0100, 1'b1, 1'b0, "R6");
    chk("R6", "write to no-write area", 32'(violation), 32'h1);
    acc(32'h0000_0100, 1'b0, 1'b1, "R6");
    chk("R6", "read from no-write area", 32'(violation), 32'h0);
    acc(32'h0000_03FF, 1'b1, 1'b0, "R3");
    chk("R3", "1 KB top byte hits", 32'(hitAny), 32'h1);
    acc(32'h0000_0400, 1'b1, 1'b0, "R8");
    chk("R8", "unmatched write allowed", 32'(violation), 32'h0);
    chk("R8", "unmatched has no hit", 32'(hitAny), 32'h0);

    acc(32'h0010_0400, 1'b1, 1'b0, "R5");
    chk("R5", "lowest area decides", 32'(hitIdx), 32'h3);
    chk("R5", "higher area no-write ignored", 32'(violation), 32'h0);
    acc(32'h0010_0400, 1'b0, 1'b1, "R7");
    chk("R7", "user to no-user area", 32'(violation), 32'h1);
    acc(32'h0010_0400, 1'b0, 1'b0, "R7");
    chk("R7", "privileged to no-user area", 32'(violation), 32'h0);

    acc(32'h2000_0010, 1'b1, 1'b1, "R4");
    chk("R4", "disabled area no hit", 32'(hitAny), 32'h0);

    acc(32'h300F_FFFF, 1'b1, 1'b0, "R3");
    chk("R3", "clamped size top", 32'(hitIdx), 32'h9);
    chk("R3", "clamped size violation", 32'(violation), 32'h1);
    acc(32'h3010_0000, 1'b1, 1'b0, "R3");
    chk("R3", "clamped size beyond", 32'(hitAny), 32'h0);

    acc(32'hF000_1234, 1'b1, 1'b0, "R9");
    chk("R9", "peripheral privileged write", 32'(violation), 32'h0);
    chk("R9", "peripheral no area hit", 32'(hitAny), 32'h0);
    acc(32'hF000_1234, 1'b0, 1'b1, "R9");
    chk("R9", "peripheral user read", 32'(violation), 32'h1);

    // R11: same-cycle response and idle quiet
    cyc(1'b0, 5'd0, 32'h0, 1'b0, 32'h0000_0100, 1'b1, 1'b1, "R11");
    chk("R11", "no access no violation", 32'(violation), 32'h0);
    acc(32'h0000_0200, 1'b1, 1'b0, "R11");
    acc(32'h0000_0800, 1'b1, 1'b0, "R11");

    // R12: out-of-range index
    wr(5'd20, 32'hFFFF_FFFF, "R12");
    chk("R12", "out-of-range read", cfgRdata, 32'h0);
    for (int i = 0; i <= 16; i++)
      cyc(1'b0, 5'(i), 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, "R12");
    cyc(1'b0, 5'd0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, "R12");
    chk("R12", "area0 untouched", cfgRdata, 32'h0000_0003);

    // Mixed register writes and accesses in the same cycles
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [4:0] idx = 5'($urandom % 20);
      logic we = ($urandom % 6) == 0;
      logic [31:0] wd = $urandom;
      if (idx == 16) wd[0] = ($urandom % 4) != 0;
      if ($urandom % 4 != 0) a = (mArea[$urandom % 16] & 32'hFFFF_FC00) + ($urandom % 4096);
      else a = $urandom;
      cyc(we, idx, wd, ($urandom % 8) != 0, a, 1'($urandom), 1'($urandom), "R5");
    end

    wr(5'd16, 32'h0, "R10");
    acc(32'hF000_0000, 1'b1, 1'b1, "R10");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule